// File: doc/BRIEF.md
# TDM Slot Serializer with Shared Buffer Index

This block is the serial frame engine of a time-division multiplexed link to a data converter. Each frame holds up to 16 time slots, and each slot carries one word of 4 to 16 bits. The word is shifted one bit per bit-clock enable. A frame begins when an external frame-start strobe is seen on a bit-clock enable. After the last slot of the frame the engine waits for the next strobe.

Each slot has a transmit-enable bit and a receive-enable bit. The two masks act independently on the data. One buffer index serves both directions and points at one of up to four 16-bit locations. The index moves forward at the end of any slot that has either enable set. A received word always goes into the same location that the transmitted word of that slot was read from. This keeps the two directions aligned even when a frame sends fewer words than it receives.

Received words are stored one per location and are never packed. They are left-justified and their unused low bits are cleared. When the index wraps back to location 0, a one-cycle buffer-full pulse is given to the status logic.

Top module: `tdm_slot_engine`

## Requirements
- R1: After a synchronous reset: buf_idx is 0, every rx_words location is 0, buf_full is 0 and sdo is 0.
- R2: The word size is wsz_m1+1 bits when wsz_m1 is 3 or more. A wsz_m1 of 0, 1 or 2 gives 4-bit words. A slot ends on the bit-clock enable that carries its last bit.
- R3: When a slot ends and bit rx_mask[slot] is 1, the word shifted in during that slot goes into location buf_idx of rx_words (bits [16*i+15:16*i] for location i). It is available from the next cycle. The first bit received is the word's MSB, the word is left-justified in the 16-bit location, and the low 16-size bits are 0.
- R4: A slot whose rx_mask bit is 0 leaves every rx_words location unchanged.
- R5: At the end of a slot, buf_idx moves to the next location if tx_mask[slot] or rx_mask[slot] is 1. If both bits are 0, buf_idx holds its value.
- R6: When buf_idx is at or above buf_len_m1 and it would advance, it goes to 0 instead. buf_full is then 1 for exactly the one cycle after that clock edge, and 0 at all other times.
- R7: During bit b of a slot whose tx_mask bit is 1, sdo is bit 15-b of location buf_idx of tx_words. The word is therefore sent MSB first. sdo is 0 during a slot whose tx_mask bit is 0, and 0 while no frame is active.
- R8: A frame has slots_m1+1 slots, and after it the engine stays idle until a new frame-start. A frame-start on the same enable as the last bit of a frame completes that slot and starts slot 0 at once. buf_idx is carried across frame boundaries without change.
- R9: With a 2-slot frame, tx_mask 0x0001, rx_mask 0x0003 and 4 locations, transmit reads locations 0 and 2 in alternate frames, and receive fills locations 0, 1, 2 and 3 over two frames.
- R10: In a cycle where bit_en is 0, the engine changes no state. sdi and frame_start have no effect in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one serial bit per asserted cycle |
| frame_start | input | 1 | Frame-start strobe, sampled with bit_en |
| slots_m1 | input | 4 | Slots per frame minus one |
| wsz_m1 | input | 4 | Word size minus one (values below 3 select 4 bits) |
| buf_len_m1 | input | 2 | Active buffer locations minus one |
| tx_mask | input | 16 | Transmit enable per slot |
| rx_mask | input | 16 | Receive enable per slot |
| tx_words | input | 64 | Four transmit locations, location i at [16*i+15:16*i] |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| rx_words | output | 64 | Four receive locations, location i at [16*i+15:16*i] |
| buf_idx | output | 2 | Shared buffer index |
| buf_full | output | 1 | One-cycle pulse when the index wraps to 0 |

## Verification
The bench builds the engine with its default parameters: 16 slots, 16-bit words and 4 locations. These defaults put every word size from 4 to 16 bits and every buffer length from 1 to 4 within reach of a near-exhaustive sweep. The sweep uses a five-slot frame whose masks mix transmit-only, receive-only, both, and neither, so wraps fall at every possible slot. Separate runs cover a full 16-slot frame, the clamped small word sizes, back-to-back frames and idle gaps. Every bit of sdo and every stored location is compared against values worked out in the bench.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int SLOTS    = 16;
    localparam int WORD_W   = 16;
    localparam int LOCS     = 4;
    localparam int MIN_WORD = 4;

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int IDX_W  = $clog2(LOCS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [BIT_W-1:0]  bitpos_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [SLOTS-1:0]  mask_t;

    // Position of the serializer inside a frame
    typedef struct packed {
        logic    active;
        slot_t   slot;
        bitpos_t bitpos;
    } frame_pos_t;

    // End-of-slot event
    typedef struct packed {
        logic  valid;
        slot_t slot;
    } slot_evt_t;

    // Last bit position of a slot for a given size-minus-one field
    function automatic bitpos_t eff_last(input bitpos_t m1);
        return (m1 < bitpos_t'(MIN_WORD - 1)) ? bitpos_t'(MIN_WORD - 1) : m1;
    endfunction

    // Left-justify the low (last+1) bits of a shift register image
    function automatic word_t left_justify(input word_t sh, input bitpos_t last);
        bitpos_t amount;
        amount = bitpos_t'(WORD_W - 1) - last;
        return sh << amount;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       frame_start,
    input  slot_t      slots_m1,
    input  bitpos_t    wsz_m1,
    output frame_pos_t pos_o,
    output slot_evt_t  evt_o,
    output logic       shift_now,
    output bitpos_t    last_o
);

    frame_pos_t pos_q, pos_d;
    bitpos_t    last;
    logic       at_last;

    always_comb begin
        last      = eff_last(wsz_m1);
        at_last   = (pos_q.bitpos >= last);
        shift_now = bit_en && pos_q.active;
        evt_o.valid = shift_now && at_last;
        evt_o.slot  = pos_q.slot;

        pos_d = pos_q;
        if (bit_en) begin
            if (pos_q.active) begin
                if (at_last) begin
                    pos_d.bitpos = '0;
                    if (pos_q.slot >= slots_m1) begin
                        pos_d.active = 1'b0;
                    end else begin
                        pos_d.slot = pos_q.slot + 1'b1;
                    end
                end else begin
                    pos_d.bitpos = pos_q.bitpos + 1'b1;
                end
            end
            if (frame_start) begin
                pos_d.active = 1'b1;
                pos_d.slot   = '0;
                pos_d.bitpos = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_o  = pos_q;
    assign last_o = last;

endmodule

// File: rtl/tdm_buf_index.sv
module tdm_buf_index
    import tdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_evt_t evt,
    input  mask_t     tx_mask,
    input  mask_t     rx_mask,
    input  idx_t      len_m1,
    output idx_t      idx_o,
    output logic      full_o
);

    idx_t idx_q;
    logic full_q;
    logic step;

    assign step = evt.valid && (tx_mask[evt.slot] || rx_mask[evt.slot]);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            full_q <= 1'b0;
        end else begin
            full_q <= 1'b0;
            if (step) begin
                if (idx_q >= len_m1) begin
                    idx_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign idx_o  = idx_q;
    assign full_o = full_q;

endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
    import tdm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_now,
    input  logic                   sdi,
    input  slot_evt_t              evt,
    input  mask_t                  rx_mask,
    input  idx_t                   idx,
    input  bitpos_t                last,
    output logic [LOCS*WORD_W-1:0] rx_flat
);

    word_t sh_q, sh_d, store_word;
    logic  wr;

    assign sh_d       = {sh_q[WORD_W-2:0], sdi};
    assign store_word = left_justify(sh_d, last);
    assign wr         = evt.valid && rx_mask[evt.slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (shift_now) begin
            sh_q <= sh_d;
        end
    end

    for (genvar g = 0; g < LOCS; g++) begin : g_loc
        word_t loc_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                loc_q <= '0;
            end else if (wr && (idx == idx_t'(g))) begin
                loc_q <= store_word;
            end
        end
        assign rx_flat[g*WORD_W +: WORD_W] = loc_q;
    end

endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
    import tdm_pkg::*;
(
    input  frame_pos_t             pos,
    input  mask_t                  tx_mask,
    input  idx_t                   idx,
    input  logic [LOCS*WORD_W-1:0] tx_flat,
    output logic                   sdo
);

    word_t   locs [LOCS];
    bitpos_t sel;

    for (genvar g = 0; g < LOCS; g++) begin : g_unpack
        assign locs[g] = tx_flat[g*WORD_W +: WORD_W];
    end

    assign sel = bitpos_t'(WORD_W - 1) - pos.bitpos;
    assign sdo = pos.active && tx_mask[pos.slot] && locs[idx][sel];

endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine
    import tdm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_en,
    input  logic                        frame_start,
    input  logic [SLOT_W-1:0]           slots_m1,
    input  logic [BIT_W-1:0]            wsz_m1,
    input  logic [IDX_W-1:0]            buf_len_m1,
    input  logic [SLOTS-1:0]            tx_mask,
    input  logic [SLOTS-1:0]            rx_mask,
    input  logic [LOCS*WORD_W-1:0]      tx_words,
    input  logic                        sdi,
    output logic                        sdo,
    output logic [LOCS*WORD_W-1:0]      rx_words,
    output logic [IDX_W-1:0]            buf_idx,
    output logic                        buf_full
);

    frame_pos_t frm_pos;
    slot_evt_t  slot_evt;
    logic       shift_now;
    bitpos_t    last_bit;

    tdm_frame_timer i_timer (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .slots_m1    (slots_m1),
        .wsz_m1      (wsz_m1),
        .pos_o       (frm_pos),
        .evt_o       (slot_evt),
        .shift_now   (shift_now),
        .last_o      (last_bit)
    );

    tdm_buf_index i_index (
        .clk     (clk),
        .rst     (rst),
        .evt     (slot_evt),
        .tx_mask (tx_mask),
        .rx_mask (rx_mask),
        .len_m1  (buf_len_m1),
        .idx_o   (buf_idx),
        .full_o  (buf_full)
    );

    tdm_rx_capture i_rx (
        .clk       (clk),
        .rst       (rst),
        .shift_now (shift_now),
        .sdi       (sdi),
        .evt       (slot_evt),
        .rx_mask   (rx_mask),
        .idx       (buf_idx),
        .last      (last_bit),
        .rx_flat   (rx_words)
    );

    tdm_tx_mux i_tx (
        .pos     (frm_pos),
        .tx_mask (tx_mask),
        .idx     (buf_idx),
        .tx_flat (tx_words),
        .sdo     (sdo)
    );

endmodule

// File: rtl/tdm_engine_checker.sv
module tdm_engine_checker
    import tdm_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   bit_en,
    input logic                   sdo,
    input logic                   pos_active,
    input logic                   evt_valid,
    input slot_t                  evt_slot,
    input mask_t                  tx_mask,
    input mask_t                  rx_mask,
    input idx_t                   buf_idx,
    input logic                   buf_full,
    input logic [LOCS*WORD_W-1:0] rx_words
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (buf_idx == '0) && !buf_full && (rx_words == '0));

    assert_rx_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !rx_mask[evt_slot]) |=> $stable(rx_words));

    assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !tx_mask[evt_slot] && !rx_mask[evt_slot]) |=> $stable(buf_idx));

    assert_full_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> (buf_idx == '0));

    assert_full_single_R6: assert property (@(posedge clk) disable iff (rst)
        buf_full |=> !buf_full);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !pos_active |-> !sdo);

    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(buf_idx) && $stable(rx_words)));

endmodule

bind tdm_slot_engine tdm_engine_checker i_checker (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .sdo        (sdo),
    .pos_active (frm_pos.active),
    .evt_valid  (slot_evt.valid),
    .evt_slot   (slot_evt.slot),
    .tx_mask    (tx_mask),
    .rx_mask    (rx_mask),
    .buf_idx    (buf_idx),
    .buf_full   (buf_full),
    .rx_words   (rx_words)
);

// File: tb/test_tdm_slot_engine.sv
`timescale 1ns/1ps
module test_tdm_slot_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        frame_start = 1'b0;
    logic [3:0]  slots_m1 = '0;
    logic [3:0]  wsz_m1 = 4'd15;
    logic [1:0]  buf_len_m1 = 2'd3;
    logic [15:0] tx_mask = '0;
    logic [15:0] rx_mask = '0;
    logic [63:0] tx_words;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [63:0] rx_words;
    logic [1:0]  buf_idx;
    logic        buf_full;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] txw [4];
    logic [15:0] exp_rx [4];
    int          m_idx;

    always #10 clk = ~clk;

    assign tx_words = {txw[3], txw[2], txw[1], txw[0]};

    tdm_slot_engine i_tdm_slot_engine (
        .clk(clk), .rst(rst), .bit_en(bit_en), .frame_start(frame_start),
        .slots_m1(slots_m1), .wsz_m1(wsz_m1), .buf_len_m1(buf_len_m1),
        .tx_mask(tx_mask), .rx_mask(rx_mask), .tx_words(tx_words),
        .sdi(sdi), .sdo(sdo), .rx_words(rx_words), .buf_idx(buf_idx),
        .buf_full(buf_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_pack();
        return {exp_rx[3], exp_rx[2], exp_rx[1], exp_rx[0]};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_idx = 0;
        for (int i = 0; i < 4; i++) exp_rx[i] = '0;
    endtask

    // One bit period: check sdo for the current bit, pulse bit_en, then one idle cycle
    task automatic tick(input bit fs, input bit din, input bit exp_sdo, input string req);
        @(negedge clk);
        chk(sdo === exp_sdo, req, "sdo", {63'd0, sdo}, {63'd0, exp_sdo});
        bit_en = 1'b1;
        frame_start = fs;
        sdi = din;
        @(negedge clk);
        bit_en = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic check_state(input bit exp_full, input string rx_req);
        chk(buf_idx == 2'(m_idx), "R5", "buf_idx", {62'd0, buf_idx}, 64'(m_idx));
        chk(buf_full === exp_full, "R6", "buf_full", {63'd0, buf_full}, {63'd0, exp_full});
        chk(rx_words === exp_pack(), rx_req, "rx_words", rx_words, exp_pack());
    endtask

    task automatic run_frame(input int ns, input int ws_m1, input logic [15:0] txm,
                             input logic [15:0] rxm, input int len, input logic [15:0] seed,
                             input bit chain_in, input bit chain_out, input bit gap,
                             input string rx_req);
        int ws;
        ws = (ws_m1 < 3) ? 4 : ws_m1 + 1;
        slots_m1   = 4'(ns - 1);
        wsz_m1     = 4'(ws_m1);
        tx_mask    = txm;
        rx_mask    = rxm;
        buf_len_m1 = 2'(len - 1);
        if (!chain_in) begin
            tick(1'b1, 1'b0, 1'b0, "R7");
            check_state(1'b0, "R8");
        end
        for (int s = 0; s < ns; s++) begin
            logic [31:0] w32;
            logic [15:0] w;
            w32 = 32'(16'hA5C3 ^ 16'(s * 16'h1357) ^ seed) & ((32'd1 << ws) - 1);
            w = w32[15:0];
            for (int b = 0; b < ws; b++) begin
                bit last, fs, e_sdo, wrap;
                last  = (b == ws - 1);
                fs    = last && (s == ns - 1) && chain_out;
                e_sdo = txm[s] ? txw[m_idx][15 - b] : 1'b0;
                tick(fs, w[ws - 1 - b], e_sdo, "R7");
                wrap = 1'b0;
                if (last) begin
                    if (rxm[s]) exp_rx[m_idx] = 16'(w32 << (16 - ws));
                    if (txm[s] || rxm[s]) begin
                        if (m_idx >= len - 1) begin
                            m_idx = 0;
                            wrap = 1'b1;
                        end else begin
                            m_idx++;
                        end
                    end
                end
                check_state(wrap, (last && rxm[s]) ? rx_req : "R4");
                if (gap && last) begin
                    logic held;
                    held = sdo;
                    for (int k = 0; k < 6; k++) begin
                        @(negedge clk);
                        sdi = k[0];
                        frame_start = 1'b1;
                    end
                    @(negedge clk);
                    frame_start = 1'b0;
                    chk(sdo === held, "R10", "sdo in gap", {63'd0, sdo}, {63'd0, held});
                    chk(buf_idx == 2'(m_idx), "R10", "buf_idx in gap", {62'd0, buf_idx}, 64'(m_idx));
                    chk(rx_words === exp_pack(), "R10", "rx in gap", rx_words, exp_pack());
                end
            end
        end
    endtask

    initial begin
        txw[0] = 16'hC3A5;
        txw[1] = 16'h5A3C;
        txw[2] = 16'h9F06;
        txw[3] = 16'h60F9;
        m_idx = 0;
        for (int i = 0; i < 4; i++) exp_rx[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(buf_idx == 2'd0, "R1", "buf_idx", {62'd0, buf_idx}, 64'd0);
        chk(rx_words == '0, "R1", "rx_words", rx_words, 64'd0);
        chk(buf_full == 1'b0, "R1", "buf_full", {63'd0, buf_full}, 64'd0);
        chk(sdo == 1'b0, "R1", "sdo", {63'd0, sdo}, 64'd0);

        // R9: 2-slot frame, transmit one word, receive two
        for (int f = 0; f < 2; f++) begin
            run_frame(2, 15, 16'h0001, 16'h0003, 4, 16'(f * 16'h1111), 1'b0, 1'b0, 1'b0, "R9");
        end
        chk(buf_idx == 2'd0, "R9", "index after two frames", {62'd0, buf_idx}, 64'd0);
        chk(rx_words === exp_pack(), "R9", "four locations filled", rx_words, exp_pack());

        // R2: sweep every word size and every buffer length
        for (int wm = 3; wm <= 15; wm++) begin
            for (int ln = 1; ln <= 4; ln++) begin
                do_reset();
                run_frame(5, wm, 16'b01011, 16'b00110, ln, 16'(wm * 77 + ln), 1'b0, 1'b0, 1'b0, "R2");
                run_frame(5, wm, 16'b01011, 16'b00110, ln, 16'(wm * 31 + ln), 1'b0, 1'b0, 1'b0, "R2");
            end
        end

        // R2: small size codes clamp to 4-bit words
        for (int wm = 0; wm < 3; wm++) begin
            run_frame(3, wm, 16'b101, 16'b111, 4, 16'(16'h0F0F + wm), 1'b0, 1'b0, 1'b0, "R2");
        end

        // R3: full 16-slot frame with mixed masks
        run_frame(16, 7, 16'hB36D, 16'h6CB5, 3, 16'h2468, 1'b0, 1'b0, 1'b0, "R3");
        run_frame(16, 11, 16'h00FF, 16'hF0F0, 4, 16'h1357, 1'b0, 1'b0, 1'b0, "R3");

        // R8: back-to-back frames, then idle enables with no frame start
        run_frame(3, 5, 16'b011, 16'b110, 4, 16'hABCD, 1'b0, 1'b1, 1'b0, "R8");
        run_frame(3, 5, 16'b011, 16'b110, 4, 16'h1234, 1'b1, 1'b1, 1'b0, "R8");
        run_frame(3, 5, 16'b011, 16'b110, 4, 16'h4321, 1'b1, 1'b0, 1'b0, "R8");
        for (int k = 0; k < 8; k++) begin
            tick(1'b0, k[0], 1'b0, "R8");
            check_state(1'b0, "R8");
        end

        // R10: idle gaps with toggling inputs inside a frame
        run_frame(4, 9, 16'b1111, 16'b1010, 2, 16'h5AA5, 1'b0, 1'b0, 1'b1, "R3");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule